// File: doc/BRIEF.md
# Maximum-Deficit Head-Cache Refill Arbiter

This block keeps the books for a small on-chip head cache that sits in front of a large external packet store holding several FIFOs. For every queue it tracks how many bytes the cache currently holds and how many bytes are already on their way from the external store. On every clock (one timeslot) a single byte may be read from the head of one named queue, which lowers that queue's count by one.

At a fixed rhythm, once every `BLOCK_BYTES` timeslots, the arbiter picks one queue to refill. It picks the queue with the most free room. The room, or deficit, is the per-queue capacity minus the bytes held minus the bytes in flight. The arbiter then raises a fetch strobe together with the queue index, asking the external store for `BLOCK_BYTES` bytes. When the store reports completion for a queue, that block moves from in flight to held. A read aimed at an empty queue sets a sticky underflow flag, which stays set until reset.

Top module: `cache_refill_arbiter`

## Requirements
- R1: While reset is asserted and right after it, every queue level reads 0, `underflow` is 0 and `fetchValid` is 0.
- R2: `fetchValid` can be 1 only in timeslot k·BLOCK_BYTES−1 counted from 0 after reset release, i.e. once in every window of BLOCK_BYTES clocks. It is 0 in all other timeslots.
- R3: In a decision timeslot, `fetchQueue` names the eligible queue with the largest deficit, where deficit = QUEUE_CAP − held − in flight, evaluated on the state at the start of that timeslot.
- R4: When several eligible queues share the largest deficit, the lowest index wins.
- R5: A queue is eligible only if its deficit is at least BLOCK_BYTES. If no queue is eligible, `fetchValid` stays 0 for that whole window.
- R6: A read to a queue whose level is nonzero lowers that queue's level by exactly 1 on the next clock. The other queues are untouched.
- R7: A read to a queue whose level is 0 sets `underflow` from the next clock until reset, and the level stays 0.
- R8: A completion naming a queue with a block in flight adds BLOCK_BYTES to that queue's level. A completion naming a queue with nothing in flight changes nothing.
- R9: A read and a credited completion on the same queue in the same timeslot give level + BLOCK_BYTES − 1 when the level was nonzero, and BLOCK_BYTES when it was zero.
- R10: No queue's level ever exceeds QUEUE_CAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A head byte is read this timeslot |
| reqQueue | input | QW | Queue read from |
| doneValid | input | 1 | Refill completion pulse from the external store |
| doneQueue | input | QW | Queue whose refill completed |
| fetchValid | output | 1 | Fetch strobe for one block |
| fetchQueue | output | QW | Queue chosen for the fetch |
| underflow | output | 1 | Sticky empty-read flag |
| levels | output | NUM_QUEUES·CW | Held bytes per queue, queue 0 in the low CW bits |

## Verification
Three events can meet in a single timeslot: a head read, a refill completion, and the refill decision. The decision looks at the pre-update state while the counters absorb all three at once. The bench aims a read and a completion at the same queue in the same cycle, including one at a queue that is empty, and lines such cycles up with decision slots. A behavioural model judges both the chosen queue and the resulting level. A long pseudo-random run mixes these coincidences with completions that name idle queues and must be ignored.

// File: rtl/cache_refill_pkg.sv
package cache_refill_pkg;

  // Strobes the control side hands to the counter datapath.
  typedef struct packed {
    logic fetchFire;   // a refill block is issued this timeslot
  } refillStrobes_t;

endpackage

// File: rtl/refill_max_pick.sv
module refill_max_pick #(
  parameter int NQ = 4,
  parameter int CW = 4,
  parameter int QW = 2
) (
  input  logic [NQ*CW-1:0] deficits,
  input  logic [NQ-1:0]    eligible,
  output logic             anyValid,
  output logic [QW-1:0]    winner
);

  logic [CW-1:0] bestDef;

  // Linear scan; strict greater-than keeps the lowest index on ties.
  always_comb begin
    anyValid = 1'b0;
    winner   = '0;
    bestDef  = '0;
    for (int k = 0; k < NQ; k++) begin
      if (eligible[k] && (!anyValid || deficits[k*CW +: CW] > bestDef)) begin
        anyValid = 1'b1;
        winner   = QW'(k);
        bestDef  = deficits[k*CW +: CW];
      end
    end
  end

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import cache_refill_pkg::*;
#(
  parameter int NQ  = 4,
  parameter int BLK = 4,
  parameter int CW  = 4,
  parameter int QW  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NQ*CW-1:0] deficits,
  input  logic [NQ-1:0]    eligible,
  output refillStrobes_t   strobes,
  output logic [QW-1:0]    pickQueue
);

  localparam int SW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int GW = $clog2(BLK + 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(BLK - 1);

  logic [SW-1:0] slotCnt;
  logic          decide;
  logic          anyValid;
  logic [QW-1:0] winner;

  always_ff @(posedge clk) begin
    if (!rstN)                slotCnt <= '0;
    else if (slotCnt == LAST_SLOT) slotCnt <= '0;
    else                      slotCnt <= slotCnt + SW'(1);
  end

  assign decide = (slotCnt == LAST_SLOT);

  refill_max_pick #(.NQ(NQ), .CW(CW), .QW(QW)) uPick (
    .deficits (deficits),
    .eligible (eligible),
    .anyValid (anyValid),
    .winner   (winner)
  );

  assign strobes.fetchFire = decide & anyValid;
  assign pickQueue         = winner;

  // Independent gap counter: cycles since reset or since the last fetch.
  logic [GW-1:0] gapCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                   gapCnt <= '0;
    else if (strobes.fetchFire)  gapCnt <= '0;
    else if (gapCnt != GW'(BLK)) gapCnt <= gapCnt + GW'(1);
  end

  // R2: two fetches are never closer than one window.
  a_r2_fetch_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetchFire |-> gapCnt >= GW'(BLK - 1));

  for (genvar k = 0; k < NQ; k++) begin : g_chk
    // R3: the chosen queue has at least the deficit of every eligible one.
    a_r3_winner_max: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.fetchFire && eligible[k]) |->
        deficits[pickQueue*CW +: CW] >= deficits[k*CW +: CW]);
    // R4: among equal deficits the lower index is taken.
    a_r4_tie_low: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.fetchFire && eligible[k] &&
       deficits[pickQueue*CW +: CW] == deficits[k*CW +: CW]) |->
        pickQueue <= QW'(k));
  end

endmodule

// File: rtl/refill_datapath.sv
module refill_datapath
  import cache_refill_pkg::*;
#(
  parameter int NQ  = 4,
  parameter int BLK = 4,
  parameter int CAP = 8,
  parameter int CW  = 4,
  parameter int QW  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [QW-1:0]    reqQueue,
  input  logic             doneValid,
  input  logic [QW-1:0]    doneQueue,
  input  refillStrobes_t   strobes,
  input  logic [QW-1:0]    pickQueue,
  output logic [NQ*CW-1:0] deficits,
  output logic [NQ-1:0]    eligible,
  output logic [NQ*CW-1:0] levels,
  output logic             underflow
);

  localparam logic [CW-1:0] BLK_C = CW'(BLK);
  localparam logic [CW-1:0] CAP_C = CW'(CAP);

  logic [NQ-1:0] emptyHit;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [CW-1:0] held;
    logic [CW-1:0] inFlight;
    logic          readHit;
    logic          take;
    logic          credit;
    logic          issue;
    logic [CW-1:0] room;

    assign readHit = reqValid && (reqQueue == QW'(g));
    assign take    = readHit && (held != '0);
    assign credit  = doneValid && (doneQueue == QW'(g)) && (inFlight != '0);
    assign issue   = strobes.fetchFire && (pickQueue == QW'(g));
    assign emptyHit[g] = readHit && (held == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        held     <= '0;
        inFlight <= '0;
      end else begin
        held     <= held - CW'(take) + (credit ? BLK_C : '0);
        inFlight <= inFlight + (issue ? BLK_C : '0) - (credit ? BLK_C : '0);
      end
    end

    assign room                = CAP_C - held - inFlight;
    assign deficits[g*CW +: CW] = room;
    assign eligible[g]         = (room >= BLK_C);
    assign levels[g*CW +: CW]  = held;

    // R10: held plus in-flight bytes never exceed the capacity.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      ({1'b0, held} + {1'b0, inFlight}) <= {1'b0, CAP_C});
    // R5: a fetch only ever lands on a queue with a full block of room.
    a_r5_fetch_room: assert property (@(posedge clk) disable iff (!rstN)
      issue |-> room >= BLK_C);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            underflow <= 1'b0;
    else if (|emptyHit)   underflow <= 1'b1;
  end

  // R7: once raised, the underflow flag holds until reset.
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);
  // R7: an empty read is always reported on the next cycle.
  a_r7_raise: assert property (@(posedge clk) disable iff (!rstN)
    (|emptyHit) |=> underflow);

endmodule

// File: rtl/cache_refill_arbiter.sv
module cache_refill_arbiter
  import cache_refill_pkg::*;
#(
  parameter int NUM_QUEUES  = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int QUEUE_CAP   = 8,
  localparam int QW = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int CW = $clog2(QUEUE_CAP + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [QW-1:0]           reqQueue,
  input  logic                    doneValid,
  input  logic [QW-1:0]           doneQueue,
  output logic                    fetchValid,
  output logic [QW-1:0]           fetchQueue,
  output logic                    underflow,
  output logic [NUM_QUEUES*CW-1:0] levels
);

  refillStrobes_t              strobes;
  logic [QW-1:0]               pickQueue;
  logic [NUM_QUEUES*CW-1:0]    deficits;
  logic [NUM_QUEUES-1:0]       eligible;

  refill_ctrl #(.NQ(NUM_QUEUES), .BLK(BLOCK_BYTES), .CW(CW), .QW(QW)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .deficits  (deficits),
    .eligible  (eligible),
    .strobes   (strobes),
    .pickQueue (pickQueue)
  );

  refill_datapath #(.NQ(NUM_QUEUES), .BLK(BLOCK_BYTES), .CAP(QUEUE_CAP),
                    .CW(CW), .QW(QW)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqQueue  (reqQueue),
    .doneValid (doneValid),
    .doneQueue (doneQueue),
    .strobes   (strobes),
    .pickQueue (pickQueue),
    .deficits  (deficits),
    .eligible  (eligible),
    .levels    (levels),
    .underflow (underflow)
  );

  assign fetchValid = strobes.fetchFire;
  assign fetchQueue = pickQueue;

endmodule

// File: tb/sim_cache_refill_arbiter.sv
module sim_cache_refill_arbiter;

  localparam int NQ  = 4;
  localparam int BB  = 4;
  localparam int CAP = 8;
  localparam int QW  = 2;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, doneValid = 1'b0;
  logic [QW-1:0] reqQueue = '0, doneQueue = '0;
  logic fetchValid, underflow;
  logic [QW-1:0] fetchQueue;
  logic [NQ*CW-1:0] levels;

  int testCnt = 0;
  int failCnt = 0;

  int mOcc[NQ];
  int mInf[NQ];
  int mSlot;
  bit mUf;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  cache_refill_arbiter #(.NUM_QUEUES(NQ), .BLOCK_BYTES(BB), .QUEUE_CAP(CAP)) u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqQueue(reqQueue),
    .doneValid(doneValid), .doneQueue(doneQueue),
    .fetchValid(fetchValid), .fetchQueue(fetchQueue),
    .underflow(underflow), .levels(levels)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lvl(int k);
    return int'(levels[k*CW +: CW]);
  endfunction

  task automatic doReset();
    rstN = 1'b0; reqValid = 1'b0; doneValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NQ; k++) chk(lvl(k) == 0, "R1 level", lvl(k), 0);
    chk(underflow == 1'b0, "R1 underflow", int'(underflow), 0);
    chk(fetchValid == 1'b0, "R1 fetch", int'(fetchValid), 0);
    rstN = 1'b1;
    for (int k = 0; k < NQ; k++) begin mOcc[k] = 0; mInf[k] = 0; end
    mSlot = 0; mUf = 1'b0;
  endtask

  // One timeslot: drive at negedge, check the decision, clock, check counters.
  task automatic step(bit rv, int rq, bit dv, int dq);
    int best, bestD, ties, d, lev;
    bit expV;
    int oldOcc[NQ];
    string tag;
    reqValid = rv; reqQueue = QW'(rq);
    doneValid = dv; doneQueue = QW'(dq);
    #1;
    best = -1; bestD = -1; ties = 0;
    for (int k = 0; k < NQ; k++) begin
      d = CAP - mOcc[k] - mInf[k];
      if (d >= BB) begin
        if (d > bestD) begin best = k; bestD = d; ties = 1; end
        else if (d == bestD) ties++;
      end
    end
    expV = (mSlot == BB - 1) && (best >= 0);
    if (mSlot != BB - 1) tag = "R2 fetch strobe";
    else if (best < 0)   tag = "R5 no eligible";
    else if (ties > 1)   tag = "R4 tie pick";
    else                 tag = "R3 max deficit";
    chk(fetchValid == expV, tag, int'(fetchValid), int'(expV));
    if (expV) chk(int'(fetchQueue) == best, tag, int'(fetchQueue), best);
    @(posedge clk);
    for (int k = 0; k < NQ; k++) oldOcc[k] = mOcc[k];
    if (rv) begin
      if (mOcc[rq] == 0) mUf = 1'b1;
      else mOcc[rq] = mOcc[rq] - 1;
    end
    if (dv && mInf[dq] > 0) begin
      mOcc[dq] = mOcc[dq] + BB;
      mInf[dq] = mInf[dq] - BB;
    end
    if (expV) mInf[best] = mInf[best] + BB;
    mSlot = (mSlot + 1) % BB;
    @(negedge clk);
    for (int k = 0; k < NQ; k++) begin
      if (rv && dv && rq == k && dq == k)         tag = "R9 read+credit level";
      else if (dv && dq == k)                     tag = "R8 credit level";
      else if (rv && rq == k && oldOcc[k] == 0)   tag = "R7 empty level";
      else                                        tag = "R6 read level";
      lev = lvl(k);
      chk(lev == mOcc[k], tag, lev, mOcc[k]);
      chk(lev <= CAP, "R10 cap", lev, CAP);
    end
    chk(underflow == mUf, "R7 underflow flag", int'(underflow), int'(mUf));
  endtask

  task automatic lfsrNext();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    doReset();
    // Idle: rotation through ties (R4), then every queue runs out of room (R5).
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0);
    // Credit every outstanding block; then completions with nothing in flight (R8).
    for (int r = 0; r < 2; r++)
      for (int q = 0; q < NQ; q++) step(0, 0, 1, q);
    for (int q = 0; q < NQ; q++) step(0, 0, 1, q);
    // Uneven draining so one queue stands out (R3, R6).
    for (int i = 0; i < 5; i++) step(1, 2, 0, 0);
    for (int i = 0; i < 2; i++) step(1, 1, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0);
    // Read and completion on the same queue in one slot (R9).
    step(1, 2, 1, 2);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0);
    // Drain queue 3 past empty without crediting it (R7), then credit while empty (R9).
    for (int i = 0; i < 12; i++) step(1, 3, 0, 0);
    step(1, 3, 1, 3);
    for (int i = 0; i < 4; i++) step(1, 3, 1, 3);
    // Pseudo-random mix of reads, completions and decisions.
    for (int i = 0; i < 3000; i++) begin
      lfsrNext();
      step(lf[0] | lf[1], int'(lf[3:2]), lf[4], int'(lf[6:5]));
    end
    // Reset clears the sticky flag and all counts (R1).
    doReset();
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0);
    finishRun();
  end

endmodule